// File: doc/BRIEF.md
# Addressed Serial Converter Code Register Front End

This block is the digital front end of an eight-channel, 8-bit converter. A host shifts a 16-bit command word into it over a three-wire serial link: a serial data line, the shift clock, and a load strobe. The word carries a chip-select field, a channel address and a data byte. When the load strobe drops, the byte is written into one of eight channel code registers. The write happens only if the word's chip-select field equals a 4-bit strap value wired on the board. Many of these blocks can therefore share one serial bus, and each one responds only to its own select code.

While the load strobe is high, the word shifts one bit per clock. The bit that leaves the top of the shift register appears on a serial output, so devices can be daisy-chained or read back. While the strobe is low, the block ignores the clock and the data line and releases the serial output (output enable low). Several devices can then share one readback wire. Reset returns every channel to mid-scale.

Top module: `sdac_front`

## Requirements
- R1: While `load_en` is 1, each rising `clk` edge shifts `ser_in` into bit 0 of a 16-bit register, and the existing contents move up by one bit. The command word is sent most significant bit first. Its layout is bits [15:12] = chip-select field (the first bit sent is the select field's bit 3), bits [11:8] = address (bit 11 is the top address bit), and bits [7:0] = data byte (bit 7 is the MSB).
- R2: `ser_out` always shows bit 15 of the shift register. While shifting, it therefore carries the bit that was sent 16 clocks earlier. `ser_out_en` equals `load_en`.
- R3: When a clock edge sees `load_en` at 0 after seeing it at 1 on the previous edge, the data byte is written into channel `addr[2:0]`. The write requires that the select field equals `strap_sel` and that address bit 3 is 0. Channel n occupies `chan_codes[8n+7:8n]`, and the new value is visible after that edge.
- R4: If the select field differs from `strap_sel` in any bit, the falling strobe changes no channel.
- R5: Any address with bit 3 = 1 (codes 8 to 15) is a no-operation: no channel changes.
- R6: While `load_en` is 0, the clock and `ser_in` do not alter the shift register, and `ser_out_en` is 0. Shifting resumes from the held contents when `load_en` returns to 1.
- R7: A synchronous active-high `rst` sets every channel to 0x80, clears the shift register to 0, and drops any pending strobe edge. It takes priority over all other inputs.
- R8: A channel is written at most once per strobe fall. Keeping `load_en` low for further clocks writes nothing more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, the only clock |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Load strobe: 1 = shift, falling edge = commit |
| ser_in | input | 1 | Serial command input, MSB first |
| strap_sel | input | 4 | Board-strapped chip-select value |
| ser_out | output | 1 | Top bit of the shift register |
| ser_out_en | output | 1 | Drive enable for `ser_out` (equals `load_en`) |
| chan_codes | output | 64 | Eight 8-bit channel codes, channel n at [8n+7:8n] |

## Verification
The assertions assume that `load_en` and `ser_in` change only away from the rising clock edge. They also assume that a strobe fall is seen by at least one clock edge before the strobe rises again. The fall is detected by sampling in the clock domain, so it would be missed if it were shorter than a clock period. The bench drives every input on the falling clock edge. It holds the strobe low for at least two clocks after each word, and it checks outputs on the falling edge after the commit edge. Stimulus covers matching, single-bit mismatching and high-address words, and a run of clocks with toggling data while the strobe is low.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 4;
    localparam int CS_W    = 4;
    localparam int FRAME_W = CS_W + ADDR_W + DATA_W;

    // Command word as it sits in the shift register, first-sent field on top
    typedef struct packed {
        logic [CS_W-1:0]   sel;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

    // True when an address selects an existing channel
    function automatic logic addr_live(input logic [ADDR_W-1:0] a, input int nch);
        return ({1'b0, a} < (ADDR_W+1)'(nch));
    endfunction

endpackage

// File: rtl/sdac_shifter.sv
module sdac_shifter
    import sdac_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load_en,
    input  logic   ser_in,
    output frame_t frame,
    output logic   load_fall,
    output logic   ser_out
);

    logic [FRAME_W-1:0] sr;
    logic               ld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr   <= '0;
            ld_q <= 1'b0;
        end else begin
            ld_q <= load_en;
            if (load_en) begin
                sr <= {sr[FRAME_W-2:0], ser_in};
            end
        end
    end

    assign frame     = frame_t'(sr);
    assign load_fall = ld_q & ~load_en;
    assign ser_out   = sr[FRAME_W-1];

    AST_SHIFT_WHEN_LOADING: assert property (@(posedge clk) disable iff (rst)
        load_en |=> (sr[FRAME_W-1:1] == $past(sr[FRAME_W-2:0])) && (sr[0] == $past(ser_in))); // R1

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(sr)); // R6

    AST_RESET_CLEARS_SHIFT: assert property (@(posedge clk)
        rst |=> (sr == '0) && !load_fall); // R7

endmodule

// File: rtl/sdac_commit.sv
module sdac_commit
    import sdac_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  frame_t            frame,
    input  logic [CS_W-1:0]   strap_sel,
    input  logic              load_fall,
    output logic [NUM_CH-1:0] we,
    output logic [DATA_W-1:0] wdata
);

    logic chip_hit;
    logic live;
    logic go;

    assign chip_hit = (frame.sel == strap_sel);
    assign live     = addr_live(frame.addr, NUM_CH);
    assign go       = load_fall & chip_hit & live;
    assign wdata    = frame.data;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        assign we[i] = go & (frame.addr == ADDR_W'(i));
    end

    AST_ONE_CHANNEL_PER_COMMIT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(we)); // R8

    AST_WE_NEEDS_FALL: assert property (@(posedge clk) disable iff (rst)
        !load_fall |-> (we == '0)); // R8

endmodule

// File: rtl/sdac_bank.sv
module sdac_bank
    import sdac_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH-1:0]        we,
    input  logic [DATA_W-1:0]        wdata,
    output logic [NUM_CH*DATA_W-1:0] codes
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic [DATA_W-1:0] code_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                code_q <= MID_CODE;
            end else if (we[i]) begin
                code_q <= wdata;
            end
        end
        assign codes[i*DATA_W +: DATA_W] = code_q;
    end

    AST_RESET_MIDSCALE: assert property (@(posedge clk)
        rst |=> (codes == {NUM_CH{MID_CODE}})); // R7

    AST_NO_WE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (we == '0) |=> $stable(codes)); // R8

endmodule

// File: rtl/sdac_front.sv
module sdac_front
    import sdac_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load_en,
    input  logic                     ser_in,
    input  logic [CS_W-1:0]          strap_sel,
    output logic                     ser_out,
    output logic                     ser_out_en,
    output logic [NUM_CH*DATA_W-1:0] chan_codes
);

    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    frame_t              frame;
    logic                load_fall;
    logic [NUM_CH-1:0]   we;
    logic [DATA_W-1:0]   wdata;
    logic [FRAME_W-1:0]  frame_bits;

    sdac_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .load_en   (load_en),
        .ser_in    (ser_in),
        .frame     (frame),
        .load_fall (load_fall),
        .ser_out   (ser_out)
    );

    sdac_commit #(.NUM_CH(NUM_CH)) u_commit (
        .clk       (clk),
        .rst       (rst),
        .frame     (frame),
        .strap_sel (strap_sel),
        .load_fall (load_fall),
        .we        (we),
        .wdata     (wdata)
    );

    sdac_bank #(.NUM_CH(NUM_CH)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .wdata (wdata),
        .codes (chan_codes)
    );

    assign ser_out_en = load_en;
    assign frame_bits = frame;

    AST_SDO_FOLLOWS_SHIFT: assert property (@(posedge clk) disable iff (rst)
        load_en |=> ser_out == $past(frame_bits[FRAME_W-2])); // R2

    AST_FOREIGN_CHIP_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (load_fall && (frame.sel != strap_sel)) |=> $stable(chan_codes)); // R4

    AST_HIGH_ADDR_NOOP: assert property (@(posedge clk) disable iff (rst)
        (load_fall && !addr_live(frame.addr, NUM_CH)) |=> $stable(chan_codes)); // R5

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (load_fall && (frame.sel == strap_sel) && addr_live(frame.addr, NUM_CH))
        |=> chan_codes[$past(frame.addr[CH_W-1:0])*DATA_W +: DATA_W] == $past(frame.data)); // R3

endmodule

// File: tb/sdac_front_tb_top.sv
`timescale 1ns/1ps
module sdac_front_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_en = 1'b0;
    logic        ser_in = 1'b0;
    logic [3:0]  strap_sel = 4'h0;
    logic        ser_out;
    logic        ser_out_en;
    logic [63:0] chan_codes;

    int total = 0;
    int bad   = 0;
    logic [7:0] model [8];

    always #2 clk = ~clk;

    sdac_front dut_i (
        .clk        (clk),
        .rst        (rst),
        .load_en    (load_en),
        .ser_in     (ser_in),
        .strap_sel  (strap_sel),
        .ser_out    (ser_out),
        .ser_out_en (ser_out_en),
        .chan_codes (chan_codes)
    );

    // {strap, select field, address, data}
    localparam logic [19:0] VEC [13] = '{
        {4'h5, 4'h5, 4'h0, 8'h11}, {4'h5, 4'h5, 4'h1, 8'h22},
        {4'h5, 4'h5, 4'h2, 8'h33}, {4'h5, 4'h5, 4'h3, 8'h44},
        {4'h5, 4'h5, 4'h4, 8'h55}, {4'h5, 4'h5, 4'h5, 8'h66},
        {4'h5, 4'h5, 4'h6, 8'h77}, {4'h5, 4'h5, 4'h7, 8'h88},
        {4'h5, 4'hA, 4'h3, 8'hFF}, {4'h5, 4'h4, 4'h2, 8'hAA},
        {4'h5, 4'h5, 4'h8, 8'hEE}, {4'h5, 4'h5, 4'hF, 8'h01},
        {4'hC, 4'hC, 4'h7, 8'h3C}
    };

    function automatic logic [63:0] model_vec();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[i*8 +: 8] = model[i];
        return v;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int b = 15; b >= 0; b--) begin
            @(negedge clk);
            load_en = 1'b1;
            ser_in  = w[b];
        end
        @(negedge clk);
        load_en = 1'b0;
        @(negedge clk);
    endtask

    // Expected effect of a word, taken from R3, R4, R5
    task automatic model_word(input logic [3:0] strap, input logic [15:0] w);
        if (w[15:12] == strap && !w[11]) model[w[10:8]] = w[7:0];
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [31:0] stream;
        logic [15:0] held;
        for (int i = 0; i < 8; i++) model[i] = 8'h80;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(chan_codes == {8{8'h80}}, "R7 reset midscale", chan_codes, {8{8'h80}});
        chk(ser_out == 1'b0, "R7 reset clears shift", 64'(ser_out), 64'd0);
        chk(ser_out_en == 1'b0, "R6 idle enable low", 64'(ser_out_en), 64'd0);

        // Table walk: R3 matching writes, R4 mismatches, R5 high addresses
        for (int v = 0; v < 13; v++) begin
            strap_sel = VEC[v][19:16];
            send_word(VEC[v][15:0]);
            model_word(VEC[v][19:16], VEC[v][15:0]);
            chk(chan_codes == model_vec(), $sformatf("R3/R4/R5 vector %0d", v), chan_codes, model_vec());
        end

        // R8: strobe held low for more clocks writes nothing more
        repeat (5) @(negedge clk);
        chk(chan_codes == model_vec(), "R8 no repeat write", chan_codes, model_vec());

        // R1/R2: serial output repeats the stream 16 shifts later
        stream = 32'hC3A5_1E96;
        for (int j = 0; j < 32; j++) begin
            @(negedge clk);
            if (j >= 16) begin
                chk(ser_out == stream[j-16], "R2 shift-out delay", 64'(ser_out), 64'(stream[j-16]));
                chk(ser_out_en == 1'b1, "R2 enable while shifting", 64'(ser_out_en), 64'd1);
            end
            load_en = 1'b1;
            ser_in  = stream[j];
        end
        @(negedge clk);
        load_en = 1'b0;
        @(negedge clk);
        // word in register = stream bits 16..31 MSB-first: sel field from stream[16..19]
        held = {stream[16], stream[17], stream[18], stream[19], stream[20], stream[21],
                stream[22], stream[23], stream[24], stream[25], stream[26], stream[27],
                stream[28], stream[29], stream[30], stream[31]};
        model_word(strap_sel, held);
        chk(chan_codes == model_vec(), "R1 frame layout commit", chan_codes, model_vec());

        // R6: idle clocks with toggling data leave the register untouched
        strap_sel = 4'h0;
        send_word(16'h9A5C);
        model_word(4'h0, 16'h9A5C);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            ser_in = k[0];
            chk(ser_out_en == 1'b0, "R6 enable low while idle", 64'(ser_out_en), 64'd0);
        end
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if (k > 0)
                chk(ser_out == held_bit(16'h9A5C, k), "R6 held contents resume", 64'(ser_out), 64'(held_bit(16'h9A5C, k)));
            load_en = 1'b1;
            ser_in  = 1'b0;
        end
        @(negedge clk);
        load_en = 1'b0;
        @(negedge clk);
        model_word(4'h0, 16'h0000);
        chk(chan_codes == model_vec(), "R3 zero word to channel 0", chan_codes, model_vec());

        // R7: reset in the middle of a word aborts it
        strap_sel = 4'h5;
        for (int b = 15; b >= 8; b--) begin
            @(negedge clk);
            load_en = 1'b1;
            ser_in  = b[0];
        end
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst     = 1'b0;
        load_en = 1'b0;
        for (int i = 0; i < 8; i++) model[i] = 8'h80;
        chk(chan_codes == model_vec(), "R7 mid-word reset", chan_codes, model_vec());
        chk(ser_out == 1'b0, "R7 shift cleared", 64'(ser_out), 64'd0);
        repeat (3) @(negedge clk);
        chk(chan_codes == model_vec(), "R7 no commit after reset", chan_codes, model_vec());
        send_word(16'h5_6_C9);
        model_word(4'h5, 16'h56C9);
        chk(chan_codes == model_vec(), "R3 write after reset", chan_codes, model_vec());

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // After k shifts on resume, the top bit is bit (15-k) of the held word
    function automatic logic held_bit(input logic [15:0] w, input int k);
        return w[15-k];
    endfunction

endmodule